// File: doc/BRIEF.md
# Packed Nibble Tag Comparator

This block verifies that each 16-byte granule covered by a memory access carries the same 4-bit tag as the pointer that makes the access. Tags sit in a tag memory with two tags per byte. The block takes a start address, the access length minus one and the pointer tag. It works out the granule range, reads the tag bytes it needs through a read port with one cycle of latency, and compares one nibble per cycle. It stops at the first mismatch. It then reports pass or fail, the number of granules that matched, a fault address and the number of bytes that can be reached before the fault.

A reverse mode scans from the granule that holds the last byte of the access down to the first granule. Backward copy engines use this mode. The controller is a five-state machine:
- ST_IDLE goes to ST_FETCH when a request is accepted.
- ST_FETCH (tag byte read issued) always goes to ST_CHECK_LIVE.
- ST_CHECK_LIVE compares against the byte arriving from memory and keeps a copy of it.
- ST_CHECK_HELD compares against that stored copy.
- Either check state goes to ST_REPORT on a mismatch or when the final granule matches. It goes to ST_FETCH when the current byte is used up, and to ST_CHECK_HELD when the other nibble of the same byte comes next.
- ST_REPORT drives the done pulse and returns to ST_IDLE.

Top module: `tag_granule_checker`

## Requirements
- R1: With first = start rounded down to 16 and last = (start + size_m1) rounded down to 16, the tag count is (last - first)/16 + 1. A request passes only if every one of these granules matches, and then match_count equals the tag count.
- R2: Granule g has its tag in tag byte g>>1. The tag is in bits [3:0] when address bit 4 of the granule is 0 (even granule) and in bits [7:4] when it is 1 (odd granule). Nibbles of granules outside the range have no effect.
- R3: Forward mode scans upward from the first granule, starting on the upper nibble when start bit 4 is set. It issues one read per tag byte, and a new read follows only after an upper nibble.
- R4: The scan stops at the first mismatching granule, and match_count is the number of granules that matched before it.
- R5: A forward failure on the first granule reports the start address as the fault address. A failure after n matches reports first + n*16.
- R6: Reverse mode scans downward from the end granule, upper nibble before lower nibble within a byte, starting on the lower nibble when end bit 4 is clear. A new read follows only after a lower nibble.
- R7: A reverse failure on the end granule reports the end address as the fault address. A failure after n matches reports (last - n*16) + 15, the top byte of the failing granule.
- R8: A forward failure reports accessible_bytes of 0 when n = 0, else n*16 - (start - first).
- R9: A reverse failure reports accessible_bytes of 0 when n = 0, else (n-1)*16 + (end + 1 - last).
- R10: On a pass, accessible_bytes is size_m1 + 1 and fault_addr is 0.
- R11: req_ready is high only in the idle state, and a request is taken when req_valid and req_ready are both high. done is a one-cycle pulse, and the results stay steady until the next request is taken.
- R12: After reset, req_ready is 1 and done and mem_rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and can take a request |
| req_reverse | input | 1 | 1 selects a backward scan |
| req_addr | input | ADDR_W | Start byte address of the access |
| req_sizem1 | input | SIZE_W | Access length in bytes minus one |
| req_tag | input | 4 | Pointer tag |
| mem_rd_en | output | 1 | Tag memory read strobe |
| mem_rd_addr | output | ADDR_W-5 | Tag byte index (granule index >> 1) |
| mem_rd_data | input | 8 | Tag byte, valid one cycle after the read strobe |
| done | output | 1 | Result valid pulse |
| pass | output | 1 | All granules matched |
| match_count | output | SIZE_W-3 | Granules matched before stopping |
| fault_addr | output | ADDR_W | Fault byte address on failure, 0 on pass |
| accessible_bytes | output | SIZE_W+1 | Bytes reachable before the fault |

## Verification
A scan position that is off by one granule, or a nibble select that is inverted, shows at the ports in two ways. The read address goes wrong at the next byte boundary, and the done of that same request carries a wrong match_count or fault address. The bench also counts tag reads per request, so an extra or missing fetch is caught even when the final verdict happens to be right. Opposite-valued tags are placed just outside the range, so a scan that overruns its end turns a pass into a fail on that request. A wrong end-granule computation only affects accesses that cross a granule, so the sweep covers every start offset within a byte pair against sizes on both sides of each 16-byte boundary.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK_LIVE,
        ST_CHECK_HELD,
        ST_REPORT
    } tgc_state_t;

    // Put the pointer tag into both nibble slots of a byte
    function automatic logic [7:0] tgc_spread(input logic [3:0] t);
        return {t, t};
    endfunction

endpackage

// File: rtl/tgc_range_calc.sv
module tgc_range_calc #(
    parameter int ADDR_W    = 16,
    parameter int SIZE_W    = 6,
    parameter int GRAN_LOG2 = 4,
    parameter int CNT_W     = 3
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [SIZE_W-1:0]           sizem1,
    output logic [ADDR_W-1:0]           end_addr,
    output logic [ADDR_W-GRAN_LOG2-1:0] first_g,
    output logic [ADDR_W-GRAN_LOG2-1:0] last_g,
    output logic [CNT_W-1:0]            count
);
    localparam int GIDX_W = ADDR_W - GRAN_LOG2;

    logic [GIDX_W-1:0] span;

    always_comb begin
        end_addr = addr + ADDR_W'(sizem1);
        first_g  = addr[ADDR_W-1:GRAN_LOG2];
        last_g   = end_addr[ADDR_W-1:GRAN_LOG2];
        span     = last_g - first_g;
        count    = CNT_W'(span) + CNT_W'(1);
    end

endmodule

// File: rtl/tgc_nibble_cmp.sv
module tgc_nibble_cmp (
    input  logic [7:0] tag_byte,
    input  logic [3:0] ptr_tag,
    input  logic       sel_upper,
    output logic       match
);
    import tgc_pkg::*;

    logic [7:0] diff;

    always_comb begin
        diff  = tag_byte ^ tgc_spread(ptr_tag);
        match = sel_upper ? (diff[7:4] == 4'd0) : (diff[3:0] == 4'd0);
    end

endmodule

// File: rtl/tgc_result_calc.sv
module tgc_result_calc #(
    parameter int ADDR_W    = 16,
    parameter int SIZE_W    = 6,
    parameter int GRAN_LOG2 = 4,
    parameter int CNT_W     = 3
) (
    input  logic                        reverse,
    input  logic                        pass,
    input  logic [CNT_W-1:0]            n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [ADDR_W-1:0]           end_addr,
    input  logic [ADDR_W-GRAN_LOG2-1:0] first_g,
    input  logic [ADDR_W-GRAN_LOG2-1:0] last_g,
    input  logic [SIZE_W-1:0]           sizem1,
    output logic [ADDR_W-1:0]           fault_addr,
    output logic [SIZE_W:0]             accessible
);
    localparam int GIDX_W = ADDR_W - GRAN_LOG2;
    localparam int ACC_W  = SIZE_W + 1;

    logic [GIDX_W-1:0] fail_g;
    logic [ACC_W-1:0]  n_bytes;

    always_comb begin
        n_bytes = ACC_W'(n) << GRAN_LOG2;
        fail_g  = reverse ? (last_g - GIDX_W'(n)) : (first_g + GIDX_W'(n));
        if (pass) begin
            fault_addr = '0;
            accessible = ACC_W'(sizem1) + ACC_W'(1);
        end else if (n == '0) begin
            fault_addr = reverse ? end_addr : addr;
            accessible = '0;
        end else if (reverse) begin
            fault_addr = {fail_g, {GRAN_LOG2{1'b1}}};
            accessible = n_bytes - (ACC_W'(1) << GRAN_LOG2)
                       + ACC_W'(end_addr[GRAN_LOG2-1:0]) + ACC_W'(1);
        end else begin
            fault_addr = {fail_g, {GRAN_LOG2{1'b0}}};
            accessible = n_bytes - ACC_W'(addr[GRAN_LOG2-1:0]);
        end
    end

endmodule

// File: rtl/tag_granule_checker.sv
module tag_granule_checker #(
    parameter int ADDR_W    = 16,
    parameter int SIZE_W    = 6,
    parameter int GRAN_LOG2 = 4,
    parameter int CNT_W     = SIZE_W - GRAN_LOG2 + 1,
    parameter int MEM_AW    = ADDR_W - GRAN_LOG2 - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_reverse,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_sizem1,
    input  logic [3:0]        req_tag,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              done,
    output logic              pass,
    output logic [CNT_W-1:0]  match_count,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [SIZE_W:0]   accessible_bytes
);
    import tgc_pkg::*;

    localparam int GIDX_W = ADDR_W - GRAN_LOG2;

    tgc_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q, end_q, req_end;
    logic [SIZE_W-1:0] sizem1_q;
    logic [3:0]        tag_q;
    logic              rev_q, pass_q;
    logic [GIDX_W-1:0] first_g_q, last_g_q, cur_g_q;
    logic [GIDX_W-1:0] req_first_g, req_last_g;
    logic [CNT_W-1:0]  total_q, req_count, n_q, n_inc;
    logic [7:0]        byte_q, cmp_byte;
    logic              nib_match, last_hit, byte_used;
    logic [ADDR_W-1:0] res_fault;
    logic [SIZE_W:0]   res_acc;

    tgc_range_calc #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .GRAN_LOG2(GRAN_LOG2), .CNT_W(CNT_W)
    ) u_range (
        .addr(req_addr), .sizem1(req_sizem1), .end_addr(req_end),
        .first_g(req_first_g), .last_g(req_last_g), .count(req_count)
    );

    assign cmp_byte = (state_q == ST_CHECK_LIVE) ? mem_rd_data : byte_q;

    tgc_nibble_cmp u_cmp (
        .tag_byte(cmp_byte), .ptr_tag(tag_q), .sel_upper(cur_g_q[0]),
        .match(nib_match)
    );

    tgc_result_calc #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .GRAN_LOG2(GRAN_LOG2), .CNT_W(CNT_W)
    ) u_result (
        .reverse(rev_q), .pass(pass_q), .n(n_q), .addr(addr_q),
        .end_addr(end_q), .first_g(first_g_q), .last_g(last_g_q),
        .sizem1(sizem1_q), .fault_addr(res_fault), .accessible(res_acc)
    );

    assign n_inc     = n_q + CNT_W'(1);
    assign last_hit  = (n_inc == total_q);
    // forward leaves a byte after its upper nibble, reverse after its lower
    assign byte_used = rev_q ? ~cur_g_q[0] : cur_g_q[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = ST_FETCH;
            ST_FETCH:      state_d = ST_CHECK_LIVE;
            ST_CHECK_LIVE,
            ST_CHECK_HELD: begin
                if (!nib_match || last_hit) state_d = ST_REPORT;
                else if (byte_used)         state_d = ST_FETCH;
                else                        state_d = ST_CHECK_HELD;
            end
            ST_REPORT:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // scan datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            end_q     <= '0;
            sizem1_q  <= '0;
            tag_q     <= '0;
            rev_q     <= 1'b0;
            pass_q    <= 1'b0;
            first_g_q <= '0;
            last_g_q  <= '0;
            cur_g_q   <= '0;
            total_q   <= '0;
            n_q       <= '0;
            byte_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q    <= req_addr;
                        end_q     <= req_end;
                        sizem1_q  <= req_sizem1;
                        tag_q     <= req_tag;
                        rev_q     <= req_reverse;
                        first_g_q <= req_first_g;
                        last_g_q  <= req_last_g;
                        total_q   <= req_count;
                        cur_g_q   <= req_reverse ? req_last_g : req_first_g;
                        n_q       <= '0;
                        pass_q    <= 1'b0;
                    end
                end
                ST_CHECK_LIVE, ST_CHECK_HELD: begin
                    if (state_q == ST_CHECK_LIVE) byte_q <= mem_rd_data;
                    if (nib_match) begin
                        n_q     <= n_inc;
                        pass_q  <= last_hit;
                        cur_g_q <= rev_q ? (cur_g_q - GIDX_W'(1))
                                         : (cur_g_q + GIDX_W'(1));
                    end else begin
                        pass_q  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready        = (state_q == ST_IDLE);
        mem_rd_en        = (state_q == ST_FETCH);
        mem_rd_addr      = cur_g_q[GIDX_W-1:1];
        done             = (state_q == ST_REPORT);
        pass             = pass_q;
        match_count      = n_q;
        fault_addr       = res_fault;
        accessible_bytes = res_acc;
    end

endmodule

// File: rtl/tgc_checker.sv
module tgc_checker #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 6,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_en,
    input logic              done,
    input logic              pass,
    input logic [CNT_W-1:0]  match_count,
    input logic [CNT_W-1:0]  total,
    input logic [SIZE_W-1:0] sizem1,
    input logic [ADDR_W-1:0] fault_addr,
    input logic [SIZE_W:0]   accessible_bytes
);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !(mem_rd_en || done));

    assert_pass_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (match_count == total));

    assert_fail_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (match_count < total));

    assert_pass_bytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (accessible_bytes == (SIZE_W+1)'(sizem1) + 1'b1
                            && fault_addr == '0));

    assert_zero_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass && match_count == '0) |-> (accessible_bytes == '0));

endmodule

bind tag_granule_checker tgc_checker #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
) u_tgc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .done(done), .pass(pass),
    .match_count(match_count), .total(total_q), .sizem1(sizem1_q),
    .fault_addr(fault_addr), .accessible_bytes(accessible_bytes)
);

// File: tb/tag_granule_checker_tb_top.sv
`timescale 1ns/1ps
module tag_granule_checker_tb_top;

    localparam int ADDR_W = 16;
    localparam int SIZE_W = 6;
    localparam int CNT_W  = SIZE_W - 4 + 1;
    localparam int MEM_AW = ADDR_W - 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_reverse = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SIZE_W-1:0] req_sizem1 = '0;
    logic [3:0]        req_tag = '0;
    logic              mem_rd_en;
    logic [MEM_AW-1:0] mem_rd_addr;
    logic [7:0]        mem_rd_data = '0;
    logic              done, pass;
    logic [CNT_W-1:0]  match_count;
    logic [ADDR_W-1:0] fault_addr;
    logic [SIZE_W:0]   accessible_bytes;

    logic [7:0] tmem [0:(1<<MEM_AW)-1];
    int rd_total = 0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tag_granule_checker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_reverse(req_reverse), .req_addr(req_addr), .req_sizem1(req_sizem1),
        .req_tag(req_tag), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .done(done), .pass(pass),
        .match_count(match_count), .fault_addr(fault_addr),
        .accessible_bytes(accessible_bytes)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= tmem[mem_rd_addr];
            rd_total    <= rd_total + 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2 packing: granule g lives in byte g>>1, lower nibble when g even
    function automatic int tag_of(input int g);
        return (g % 2 == 1) ? int'(tmem[g/2][7:4]) : int'(tmem[g/2][3:0]);
    endfunction

    task automatic set_tag(input int g, input int t);
        if (g % 2 == 1) tmem[g/2][7:4] = 4'(t);
        else            tmem[g/2][3:0] = 4'(t);
    endtask

    task automatic run_case(input int addr, input int sm1, input int tag,
                            input bit rev, input int bad);
        int first, last, cnt, n, stop_g, start_g, exp_fault, exp_acc, exp_rd;
        int rd0, wait_c, endad;
        bit exp_pass;
        endad = addr + sm1;
        first = addr / 16;
        last  = endad / 16;
        cnt   = last - first + 1;
        for (int g = first - 2; g <= last + 2; g++)
            set_tag(g, (g >= first && g <= last) ? tag : (tag ^ 15));
        if (bad >= 0 && bad < cnt)
            set_tag(rev ? last - bad : first + bad, tag ^ 8);
        n = 0;
        for (int k = 0; k < cnt; k++) begin
            if (tag_of(rev ? last - k : first + k) != tag) break;
            n++;
        end
        exp_pass = (n == cnt);
        start_g  = rev ? last : first;
        stop_g   = exp_pass ? (rev ? first : last) : (rev ? last - n : first + n);
        exp_rd   = (rev ? (start_g / 2 - stop_g / 2) : (stop_g / 2 - start_g / 2)) + 1;
        if (exp_pass) begin
            exp_fault = 0;
            exp_acc   = sm1 + 1;
        end else if (n == 0) begin
            exp_fault = rev ? endad : addr;
            exp_acc   = 0;
        end else if (rev) begin
            exp_fault = (last - n) * 16 + 15;
            exp_acc   = (n - 1) * 16 + (endad + 1 - last * 16);
        end else begin
            exp_fault = (first + n) * 16;
            exp_acc   = n * 16 - (addr - first * 16);
        end

        @(negedge clk);
        rd0         = rd_total;
        req_valid   = 1'b1;
        req_reverse = rev;
        req_addr    = ADDR_W'(addr);
        req_sizem1  = SIZE_W'(sm1);
        req_tag     = 4'(tag);
        @(negedge clk);
        req_valid = 1'b0;
        wait_c = 0;
        while (!done && wait_c < 100) begin
            @(negedge clk);
            wait_c++;
        end
        check("R11 done seen", done, 1);
        check(exp_pass ? "R1 pass" : "R4 pass", pass, exp_pass);
        check(rev ? "R6 match_count" : "R2 R4 match_count", match_count, n);
        check(rev ? "R6 reads" : "R3 reads", rd_total - rd0, exp_rd);
        if (exp_pass) begin
            check("R10 fault", fault_addr, 0);
            check("R10 bytes", accessible_bytes, exp_acc);
        end else begin
            check(rev ? "R7 fault" : "R5 fault", fault_addr, exp_fault);
            check(rev ? "R9 bytes" : "R8 bytes", accessible_bytes, exp_acc);
        end
        @(negedge clk);
        check("R11 done pulse", done, 0);
        check("R11 held count", match_count, n);
        check("R11 ready", req_ready, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int sizes[8] = '{0, 1, 15, 16, 17, 31, 47, 63};
        for (int i = 0; i < (1 << MEM_AW); i++) tmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 ready", req_ready, 1);
        check("R12 done", done, 0);
        check("R12 rd_en", mem_rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 idle after release", req_ready, 1);
        for (int off = 0; off < 32; off++)
            for (int si = 0; si < 8; si++)
                for (int rv = 0; rv < 2; rv++)
                    for (int bad = -1; bad < 5; bad++)
                        run_case(16'h0400 + off, sizes[si], (off + si) % 16,
                                 bit'(rv), bad);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule